// File: doc/BRIEF.md
# Nonvolatile User-Block Write Guard

This block stands between a host write path and a small nonvolatile memory. The memory's user area is divided into three 32-byte blocks. The guard decides whether each host write may reach the memory. It drops a write while the backend reports that a copy operation is running, and it drops a write that targets a block that has been made read-only.

Each block can be made read-only once and permanently. This takes two steps. First the host sets an arming bit through its control register. Then a lock command naming a block sets that block's flag. The arming bit clears itself after every executed lock command, so each further lock must be armed again. A lock command that arrives while the guard is not armed has no effect.

All outputs are registered, and each one changes one clock after the stimulus that causes it.

Top module: `nvm_block_guard`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `mem_we`, `lock_flags`, `copy_flag` and `lock_arm` are all 0.
- R2: The user blocks are decoded as follows: block 0 covers 20h–3Fh, block 1 covers 40h–5Fh and block 2 covers 60h–7Fh. A `wr_strobe` to any of these addresses raises `mem_we` for exactly the next cycle when the copy flag is 0 and the targeted block is not locked.
- R3: A write to an address below 20h or above 7Fh never raises `mem_we`.
- R4: `copy_flag` shows `copy_busy` one cycle late. Any write issued while `copy_flag` is 1 is dropped.
- R5: A write whose address lies in a locked block never raises `mem_we`. Writes to unlocked blocks are still accepted.
- R6: A `lock_cmd` issued while `lock_arm` is 0 changes no lock flag.
- R7: `lock_arm` resets to 0. A `ctl_we` loads it from bit 0 of `ctl_wdata` on the next cycle.
- R8: A `lock_cmd` issued while `lock_arm` is 1 clears `lock_arm` on the next cycle. If `lock_blk` is 0, 1 or 2, the same cycle sets that block's flag (`lock_flags[lock_blk]`). A target of 3 locks nothing. An executed lock takes priority over a `ctl_we` in the same cycle.
- R9: Once a lock flag is set it stays set until reset. Host writes to the read-only control bits have no effect: bits 3:1 are the lock flags and bit 4 is the copy flag.
- R10: A write issued in the same cycle as the lock command for its block is judged against the lock state from before that command, so it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_addr | input | 8 | Host write address |
| wr_strobe | input | 1 | Host write request for one cycle |
| copy_busy | input | 1 | Copy operation running in the memory backend |
| lock_cmd | input | 1 | Lock command strobe |
| lock_blk | input | 2 | Target block of the lock command |
| ctl_we | input | 1 | Host write to the control register |
| ctl_wdata | input | 8 | Control data; bit 0 is the arming bit |
| mem_we | output | 1 | Qualified write enable toward the memory |
| lock_flags | output | 3 | Per-block read-only flags |
| copy_flag | output | 1 | Registered copy-in-progress flag |
| lock_arm | output | 1 | Lock arming bit |

## Verification
Every result of this block appears exactly one clock edge after the input that causes it. This holds for the gated write enable, a newly set lock flag, the arming bit and the copy flag. When the driver applies inputs at a falling edge, it computes the expected values of all four outputs from a model of the requirements and queues them. The monitor compares that queue entry just after the following rising edge. Because of this, a stimulus is never judged against outputs from the wrong cycle, including the cases where a copy or a lock takes effect in the same cycle as a write.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;
  localparam int CTL_W       = 8;
  localparam int CTL_ARM_BIT = 0;
endpackage

// File: rtl/nvm_guard_decode.sv
module nvm_guard_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_BLK  = 3,
  parameter int BLK_LOG2 = 5,
  parameter int BASE     = 32'h20
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_BLK-1:0] hit
);
  localparam int TAG_W    = ADDR_W - BLK_LOG2;
  localparam int BASE_TAG = BASE >> BLK_LOG2;

  logic [TAG_W-1:0] tag;
  assign tag = addr[ADDR_W-1:BLK_LOG2];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    assign hit[b] = (tag == TAG_W'(BASE_TAG + b));
  end
endmodule

// File: rtl/nvm_guard_locks.sv
module nvm_guard_locks #(
  parameter int NUM_BLK = 3,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lock_cmd,
  input  logic [SEL_W-1:0]   lock_sel,
  input  logic               ctl_we,
  input  logic               ctl_arm,
  output logic [NUM_BLK-1:0] flags,
  output logic               arm
);
  logic do_lock;
  assign do_lock = lock_cmd & arm;

  always_ff @(posedge clk) begin
    if (rst)          arm <= 1'b0;
    else if (do_lock) arm <= 1'b0;
    else if (ctl_we)  arm <= ctl_arm;
  end

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                                       flags[b] <= 1'b0;
      else if (do_lock && (lock_sel == SEL_W'(b)))   flags[b] <= 1'b1;
    end
  end
endmodule

// File: rtl/nvm_guard_gate.sv
module nvm_guard_gate #(
  parameter int NUM_BLK = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_strobe,
  input  logic [NUM_BLK-1:0] hit,
  input  logic [NUM_BLK-1:0] locked,
  input  logic               copy_flag,
  output logic               mem_we
);
  logic open_hit;
  assign open_hit = |(hit & ~locked);

  always_ff @(posedge clk) begin
    if (rst) mem_we <= 1'b0;
    else     mem_we <= wr_strobe & open_hit & ~copy_flag;
  end
endmodule

// File: rtl/nvm_block_guard.sv
module nvm_block_guard
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_BLK  = 3,
  parameter int BLK_LOG2 = 5,
  parameter int BASE     = 32'h20,
  parameter int SEL_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic                 wr_strobe,
  input  logic                 copy_busy,
  input  logic                 lock_cmd,
  input  logic [SEL_W-1:0]     lock_blk,
  input  logic                 ctl_we,
  input  logic [CTL_W-1:0]     ctl_wdata,
  output logic                 mem_we,
  output logic [NUM_BLK-1:0]   lock_flags,
  output logic                 copy_flag,
  output logic                 lock_arm
);
  logic [NUM_BLK-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) copy_flag <= 1'b0;
    else     copy_flag <= copy_busy;
  end

  nvm_guard_decode #(
    .ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK), .BLK_LOG2(BLK_LOG2), .BASE(BASE)
  ) u_decode (
    .addr(wr_addr), .hit(hit)
  );

  nvm_guard_locks #(.NUM_BLK(NUM_BLK), .SEL_W(SEL_W)) u_locks (
    .clk(clk), .rst(rst), .lock_cmd(lock_cmd), .lock_sel(lock_blk),
    .ctl_we(ctl_we), .ctl_arm(ctl_wdata[CTL_ARM_BIT]),
    .flags(lock_flags), .arm(lock_arm)
  );

  nvm_guard_gate #(.NUM_BLK(NUM_BLK)) u_gate (
    .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .hit(hit),
    .locked(lock_flags), .copy_flag(copy_flag), .mem_we(mem_we)
  );
endmodule

// File: rtl/nvm_block_guard_chk.sv
module nvm_block_guard_chk
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_BLK  = 3,
  parameter int BLK_LOG2 = 5,
  parameter int BASE     = 32'h20,
  parameter int SEL_W    = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic               wr_strobe,
  input logic               copy_busy,
  input logic               lock_cmd,
  input logic [SEL_W-1:0]   lock_blk,
  input logic               ctl_we,
  input logic [CTL_W-1:0]   ctl_wdata,
  input logic               mem_we,
  input logic [NUM_BLK-1:0] lock_flags,
  input logic               copy_flag,
  input logic               lock_arm
);
  localparam int LO = BASE;
  localparam int HI = BASE + NUM_BLK * (1 << BLK_LOG2);

  logic in_rng;
  logic locked_hit;
  assign in_rng = (int'(wr_addr) >= LO) && (int'(wr_addr) < HI);

  always_comb begin
    locked_hit = 1'b0;
    for (int b = 0; b < NUM_BLK; b++)
      if (in_rng && (((int'(wr_addr) - LO) >> BLK_LOG2) == b) && lock_flags[b])
        locked_hit = 1'b1;
  end

  AST_OUT_OF_RANGE_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr_strobe && !in_rng) |=> !mem_we); // R3
  AST_COPY_DROP: assert property (@(posedge clk) disable iff (rst)
    copy_flag |=> !mem_we); // R4
  AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (rst)
    locked_hit |=> !mem_we); // R5
  AST_DISARMED_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
    (!(lock_cmd && lock_arm)) |=> $stable(lock_flags)); // R6
  AST_ARM_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (lock_cmd && lock_arm) |=> !lock_arm); // R8
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((lock_flags & $past(lock_flags)) == $past(lock_flags))); // R9
  AST_WE_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    !wr_strobe |=> !mem_we); // R2
endmodule

bind nvm_block_guard nvm_block_guard_chk #(
  .ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK), .BLK_LOG2(BLK_LOG2), .BASE(BASE), .SEL_W(SEL_W)
) chk_i (.*);

// File: tb/nvm_block_guard_tb_top.sv
module nvm_block_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] wr_addr = 8'h00;
  logic       wr_strobe = 1'b0;
  logic       copy_busy = 1'b0;
  logic       lock_cmd = 1'b0;
  logic [1:0] lock_blk = 2'd0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       mem_we;
  logic [2:0] lock_flags;
  logic       copy_flag;
  logic       lock_arm;

  always #2 clk = ~clk;

  nvm_block_guard dut_i (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_strobe(wr_strobe),
    .copy_busy(copy_busy), .lock_cmd(lock_cmd), .lock_blk(lock_blk),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .mem_we(mem_we),
    .lock_flags(lock_flags), .copy_flag(copy_flag), .lock_arm(lock_arm)
  );

  typedef struct {
    logic       we;
    logic [2:0] flags;
    logic       copy;
    logic       arm;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  logic       m_copy = 1'b0;
  logic       m_arm = 1'b0;
  logic [2:0] m_flags = 3'b000;
  bit         done = 1'b0;

  task automatic step(input logic [7:0] a, input logic w, input logic cb,
                      input logic lc, input logic [1:0] lb,
                      input logic cw, input logic [7:0] cd, input string req);
    exp_t e;
    int blk;
    @(negedge clk);
    wr_addr = a; wr_strobe = w; copy_busy = cb; lock_cmd = lc;
    lock_blk = lb; ctl_we = cw; ctl_wdata = cd;
    blk = (int'(a) - 32) >> 5;
    e.we = w && (a >= 8'h20) && (a <= 8'h7F) && !m_copy && !m_flags[blk];
    if (lc && m_arm) begin
      m_arm = 1'b0;
      if (lb < 2'd3) m_flags[lb] = 1'b1;
    end else if (cw) m_arm = cd[0];
    m_copy = cb;
    e.flags = m_flags; e.copy = m_copy; e.arm = m_arm; e.req = req;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        e = exp_q.pop_front();
        checks++;
        if (mem_we !== e.we || lock_flags !== e.flags || copy_flag !== e.copy || lock_arm !== e.arm) begin
          errors++;
          $display("FAIL %s: got we=%b flags=%b copy=%b arm=%b expected we=%b flags=%b copy=%b arm=%b",
                   e.req, mem_we, lock_flags, copy_flag, lock_arm, e.we, e.flags, e.copy, e.arm);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (mem_we !== 1'b0 || lock_flags !== 3'b000 || copy_flag !== 1'b0 || lock_arm !== 1'b0) begin
      errors++;
      $display("FAIL R1: got we=%b flags=%b copy=%b arm=%b expected all 0", mem_we, lock_flags, copy_flag, lock_arm);
    end
    @(negedge clk); rst = 1'b0;
    step(8'h00, 0, 0, 0, 0, 0, 8'h00, "R1");
    // R2 block edges
    step(8'h20, 1, 0, 0, 0, 0, 8'h00, "R2");
    step(8'h3F, 1, 0, 0, 0, 0, 8'h00, "R2");
    step(8'h40, 1, 0, 0, 0, 0, 8'h00, "R2");
    step(8'h5F, 1, 0, 0, 0, 0, 8'h00, "R2");
    step(8'h60, 1, 0, 0, 0, 0, 8'h00, "R2");
    step(8'h7F, 1, 0, 0, 0, 0, 8'h00, "R2");
    // R3 outside range
    step(8'h1F, 1, 0, 0, 0, 0, 8'h00, "R3");
    step(8'h80, 1, 0, 0, 0, 0, 8'h00, "R3");
    step(8'hFF, 1, 0, 0, 0, 0, 8'h00, "R3");
    step(8'h00, 1, 0, 0, 0, 0, 8'h00, "R3");
    // R4 copy gating with one-cycle flag delay
    step(8'h30, 1, 1, 0, 0, 0, 8'h00, "R4");
    step(8'h50, 1, 1, 0, 0, 0, 8'h00, "R4");
    step(8'h50, 1, 0, 0, 0, 0, 8'h00, "R4");
    step(8'h50, 1, 0, 0, 0, 0, 8'h00, "R4");
    // R6 disarmed lock
    step(8'h00, 0, 0, 1, 1, 0, 8'h00, "R6");
    // R7 arm set and clear
    step(8'h00, 0, 0, 0, 0, 1, 8'h01, "R7");
    step(8'h00, 0, 0, 0, 0, 1, 8'h00, "R7");
    step(8'h00, 0, 0, 0, 0, 1, 8'h01, "R7");
    // R8 + R10 lock block 1 with a same-cycle write to it
    step(8'h45, 1, 0, 1, 1, 0, 8'h00, "R10");
    step(8'h45, 1, 0, 0, 0, 0, 8'h00, "R5");
    step(8'h25, 1, 0, 0, 0, 0, 8'h00, "R5");
    step(8'h00, 0, 0, 1, 0, 0, 8'h00, "R6");
    // R8 invalid target disarms only
    step(8'h00, 0, 0, 0, 0, 1, 8'h01, "R7");
    step(8'h00, 0, 0, 1, 3, 0, 8'h00, "R8");
    // R8 lock wins over same-cycle control write
    step(8'h00, 0, 0, 0, 0, 1, 8'h01, "R7");
    step(8'h00, 0, 0, 1, 2, 1, 8'h01, "R8");
    // R9 host writes to read-only bits
    step(8'h00, 0, 0, 0, 0, 1, 8'hFE, "R9");
    step(8'h00, 0, 0, 0, 0, 1, 8'h00, "R9");
    step(8'h65, 1, 0, 0, 0, 0, 8'h00, "R5");
    step(8'h5A, 1, 0, 0, 0, 0, 8'h00, "R5");
    step(8'h3A, 1, 0, 0, 0, 0, 8'h00, "R2");
    step(8'h00, 0, 0, 0, 0, 0, 8'h00, "R9");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule